// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers six peripheral interrupt sources into sticky pending flags and gates them with a six-bit enable mask. It drives one level-sensitive interrupt line to the CPU. Each source has its own set input and clear input. The display-processor source can also be cleared by a one-cycle pulse that comes from the neighbouring mode-register block.

Software sees three registers. The first is a read-only version word. The second is a read-only view of the pending flags. The third is the mask, which is written through pairs of set and clear bits so that one write can change some enables without disturbing the others. A source that is masked still records its event. Enabling that source later raises the CPU line straight away.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the pending flags and the mask are all 0, and `cpu_irq` is low.
- R2: A 1 on `src_set[n]` sets pending flag n at the next clock edge, whatever the mask. The pending flags read at offset 0x8 with bit 0 SP, 1 SI, 2 AI, 3 VI, 4 PI and 5 DP. Bits 31:6 of that read are 0.
- R3: A 1 on `src_clr[n]` clears pending flag n at the next edge. If a set and a clear reach the same flag in the same cycle, the flag ends up 1.
- R4: A 1 on `disp_clr` clears the DP flag (bit 5) and no other flag. A DP set in the same cycle wins.
- R5: A write to offset 0xC sets mask bit n when data bit 2n+1 is 1 and bit 2n is 0. It clears mask bit n when bit 2n is 1 and bit 2n+1 is 0. If both bits are 1, or both are 0, mask bit n keeps its value. The mask reads at offset 0xC in bits 5:0, and the other bits of that read are 0.
- R6: `cpu_irq` is high exactly when some flag is both pending and enabled. Enabling the mask for a flag that is already pending raises `cpu_irq` in the cycle that follows the write edge.
- R7: Writes to offsets 0x4 and 0x8 change neither the pending flags nor the mask.
- R8: A read at offset 0x4 returns the `VERSION` parameter, which holds four 8-bit fields.
- R9: Only address bits 3:0 are decoded, so the registers repeat every 16 bytes. Reads at offsets 0x0 and at offsets that are not word-aligned return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 6 | Per-source event pulses that set the pending flags |
| src_clr | input | 6 | Per-source acknowledge pulses that clear the pending flags |
| disp_clr | input | 1 | Clear pulse for the DP flag, driven by the mode block |
| reg_addr | input | 12 | Register byte address; only bits 3:0 are decoded |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr`, available in the same cycle |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
A wrong pending flag or mask bit appears at the ports on the very next cycle. It shows either in the read data at offset 0x8 or 0xC, or as a `cpu_irq` level that disagrees with the pending-and-enabled state. The bench therefore compares every output against its own model on every clock, so a fault is caught one cycle after the edge that caused it. Directed sequences cover the cases that random traffic reaches only rarely: a set and a clear in the same cycle, a DP clear pulse that races a DP set, write pairs with both bits high, and mirrored addresses.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int          NSRC    = 6,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0302_0104
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_set,
  input  logic [NSRC-1:0]   src_clr,
  input  logic              disp_clr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cpu_irq
);
  localparam int         DISP_IDX = NSRC - 1;
  localparam logic [3:0] OFF_VER  = 4'h4;
  localparam logic [3:0] OFF_PEND = 4'h8;
  localparam logic [3:0] OFF_MASK = 4'hC;

  logic [NSRC-1:0] pending, mask, mask_nxt, clr_all;
  logic            mask_wr;
  logic            unused_bits;

  assign unused_bits = ^{reg_addr[ADDR_W-1:4], reg_wdata[31:2*NSRC]};
  assign mask_wr     = reg_wr && (reg_addr[3:0] == OFF_MASK);
  assign clr_all     = src_clr | (NSRC'(disp_clr) << DISP_IDX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr_all) | src_set;

  always_comb begin
    mask_nxt = mask;
    for (int n = 0; n < NSRC; n++)
      case (reg_wdata[2*n+1 -: 2])
        2'b10:   mask_nxt[n] = 1'b1;
        2'b01:   mask_nxt[n] = 1'b0;
        default: mask_nxt[n] = mask[n];
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= mask_nxt;

  assign cpu_irq = |(pending & mask);

  always_comb
    case (reg_addr[3:0])
      OFF_VER:  reg_rdata = VERSION;
      OFF_PEND: reg_rdata = 32'(pending);
      OFF_MASK: reg_rdata = 32'(mask);
      default:  reg_rdata = '0;
    endcase

  a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pending & $past(src_set)) == $past(src_set)));

  a_r4_disp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_clr && !src_set[DISP_IDX]) |=> !pending[DISP_IDX]);

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask));

  a_r7_pend_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == '0 && src_clr == '0 && !disp_clr) |=> $stable(pending));

  a_r6_enable_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && reg_wdata[1:0] == 2'b10 && pending[0] && !src_clr[0]) |=> cpu_irq);
endmodule

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  src_set = 0, src_clr = 0;
  logic        disp_clr = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        cpu_irq;
  int          errors = 0, checks = 0;
  bit          m_pend[6], m_mask[6];
  localparam logic [31:0] VER = 32'h0302_0104;

  irq_mask_ctrl i_irq_mask_ctrl (.clk, .rst_n, .src_set, .src_clr, .disp_clr,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .cpu_irq);

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_mask[i] = 0; end
    end else begin
      for (int i = 0; i < 6; i++) begin
        if (src_set[i]) m_pend[i] = 1;
        else if (src_clr[i] || (i == 5 && disp_clr)) m_pend[i] = 0;
      end
      if (reg_wr && reg_addr[3:0] == 4'hC)
        for (int i = 0; i < 6; i++) begin
          if (reg_wdata[2*i+1] && !reg_wdata[2*i]) m_mask[i] = 1;
          if (reg_wdata[2*i] && !reg_wdata[2*i+1]) m_mask[i] = 0;
        end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] r = 0;
    if (a == 4'h4) r = VER;
    for (int i = 0; i < 6; i++) begin
      if (a == 4'h8) r[i] = m_pend[i];
      if (a == 4'hC) r[i] = m_mask[i];
    end
    return r;
  endfunction

  function automatic logic m_irq();
    logic x = 0;
    for (int i = 0; i < 6; i++) x = x | (m_pend[i] & m_mask[i]);
    return x;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    string tag;
    case (reg_addr[3:0])
      4'h4: tag = "R8 version"; 4'h8: tag = "R2 pending";
      4'hC: tag = "R5 mask";    default: tag = "R9 unmapped";
    endcase
    check(tag, reg_rdata, m_read(reg_addr[3:0]));
    check("R6 cpu_irq", 32'(cpu_irq), 32'(m_irq()));
  endtask

  task automatic cyc(input logic [5:0] s, c, input logic dc, w,
                     input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    compare_all();
    src_set = s; src_clr = c; disp_clr = dc; reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(0, 0, 0, 0, a, 0);
    #1 check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    rd(12'h008, 0, "R1 reset pending");
    rd(12'h00C, 0, "R1 reset mask");
    check("R1 reset irq", 32'(cpu_irq), 0);
    cyc(6'h3F, 0, 0, 0, 12'h008, 0);
    rd(12'h008, 32'h3F, "R2 all pending while masked");
    check("R2 masked irq low", 32'(cpu_irq), 0);
    cyc(0, 6'h01, 0, 0, 12'h008, 0);
    rd(12'h008, 32'h3E, "R3 clear SP");
    cyc(6'h02, 6'h02, 0, 0, 12'h008, 0);
    rd(12'h008, 32'h3E, "R3 set wins over clear");
    cyc(0, 0, 1, 0, 12'h008, 0);
    rd(12'h008, 32'h1E, "R4 disp_clr drops DP only");
    cyc(6'h20, 0, 1, 0, 12'h008, 0);
    rd(12'h008, 32'h3E, "R4 DP set wins over disp_clr");
    cyc(0, 0, 0, 1, 12'h008, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 12'h004, 32'hFFFF_FFFF);
    rd(12'h008, 32'h3E, "R7 pending unchanged by writes");
    rd(12'h00C, 0, "R7 mask unchanged by writes");
    cyc(0, 0, 0, 1, 12'h00C, 32'h0000_0AAA);
    rd(12'h00C, 32'h3F, "R5 set pairs");
    cyc(0, 0, 0, 1, 12'h00C, 32'h0000_0FF5);
    rd(12'h00C, 32'h3C, "R5 both-ones pairs hold, clear pairs clear");
    cyc(0, 6'h3F, 1, 0, 12'h000, 0);
    cyc(6'h01, 0, 0, 0, 12'h000, 0);
    cyc(0, 0, 0, 1, 12'h00C, 32'h0000_0002);
    #1 check("R6 irq low before enable edge", 32'(cpu_irq), 0);
    @(negedge clk);
    check("R6 irq high after enabling pending SP", 32'(cpu_irq), 1);
    rd(12'h30C, 32'h3D, "R9 mirrored mask read");
    rd(12'hFF4, VER, "R8 mirrored version read");
    rd(12'h006, 0, "R9 unaligned read zero");
    for (int k = 0; k < 3000; k++)
      cyc(6'($urandom) & 6'($urandom), 6'($urandom) & 6'($urandom), 1'($urandom),
          1'($urandom), 12'($urandom) & 12'hF0C | 12'h0, $urandom);
    cyc(0, 0, 0, 0, 12'h008, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule